// File: doc/BRIEF.md
# Staged Parameter Write Port for a Three-Phase Modulator

This block is the write side of an 8-bit multiplexed address/data processor bus. It feeds two 24-bit parameter words to a downstream three-phase modulator: a setup word (carrier division, frequency ceiling, dead time, minimum pulse) and a run word (start/stop, speed, direction). The bus carries only 8 bits, so software first fills three byte-wide staging slots. It then writes to one of two pseudo-addresses. That write copies all three slots into the chosen 24-bit word in a single clock. Nothing is readable.

One set of pins serves two bus styles. In the strobe style, an address latch enable and a write strobe are used and the read strobe is ignored. In the data-strobe style, an address strobe, a data strobe, a direction line and a chip select are used. A strap input picks the style while reset is applied. All bus pins are asynchronous to the block clock. They pass through a two-flop synchroniser, and their edges are found in the clock domain.

An active-low hold input keeps the modulator's outputs disabled. The setup word only accepts a commit while hold is asserted. Each commit raises a one-clock update pulse for the word that was loaded.

Top module: `wbus_param_loader`

## Requirements
- R1: While `rst` is high, `ctrl_word` and `init_word` are 0, `ctrl_upd` and `init_upd` are 0 and `drive_en` is 0.
- R2: With the strobe style selected (`proto_sel` = 0 during reset), the address is taken from `ad[2:0]` on a falling edge of `ale_as`. Data is taken from `ad` on a rising edge of `wr_ds`. `rd_rw` and `cs_n` have no effect.
- R3: With the data-strobe style selected (`proto_sel` = 1 during reset), the address is taken from `ad[2:0]` on a falling edge of `ale_as`. Data is taken on a falling edge of `wr_ds`, but only when `rd_rw` is 0 and `cs_n` is 0 at that edge. Any other data strobe is ignored.
- R4: Writes to addresses 0, 1 and 2 load staging bytes S0, S1 and S2 and leave `ctrl_word` and `init_word` unchanged.
- R5: A write to address 3 loads `ctrl_word` with {S2,S1,S0}, with S0 in bits 7:0. The data byte of that write is ignored.
- R6: A write to address 4 loads `init_word` with {S2,S1,S0} only while `hold_n` is 0. While `hold_n` is 1, the write leaves `init_word` unchanged and gives no pulse.
- R7: Writes to addresses 5, 6 and 7 change neither the staging bytes nor either word.
- R8: Each accepted commit gives exactly one `ctrl_upd` or `init_upd` pulse, one clock long, in the clock where the word changes. The two pulses are never high together, and neither word changes without its pulse.
- R9: `drive_en` follows `hold_n` after synchronisation, so it is 0 whenever hold has been asserted for a few clocks. An `init_upd` pulse only occurs while `drive_en` is 0.
- R10: The bus style is sampled from `proto_sel` only while `rst` is high. Changing `proto_sel` after reset has no effect.
- R11: Staging bytes keep their values after a commit, so a later commit reuses any byte not rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_sel | input | 1 | Bus style strap: 0 strobe style, 1 data-strobe style; sampled in reset |
| hold_n | input | 1 | Active-low output hold; enables setup-word commits |
| ad | input | 8 | Multiplexed address/data bus |
| ale_as | input | 1 | Address latch enable / address strobe (falling edge latches) |
| wr_ds | input | 1 | Write strobe (rising edge) / data strobe (falling edge) |
| rd_rw | input | 1 | Read strobe (ignored) / direction, 0 = write |
| cs_n | input | 1 | Active-low chip select, data-strobe style only |
| ctrl_word | output | 24 | Run parameter word |
| init_word | output | 24 | Setup parameter word |
| ctrl_upd | output | 1 | One-clock pulse when `ctrl_word` is loaded |
| init_upd | output | 1 | One-clock pulse when `init_word` is loaded |
| drive_en | output | 1 | Modulator output enable, low while hold is asserted |

## Verification
The hardest state to reach from the ports is the strap being changed after reset. Any bus cycle that follows is decoded in only one style, so an error shows only if the bench keeps issuing cycles of the reset-time style. The stimulus flips `proto_sel` in mid-run in both styles and then issues commits that are accepted only under the latched style. Rejected writes are exposed indirectly: data strobes with chip select high or direction high, and writes to the unused addresses, are followed by a legal commit. The committed word must still carry the old staging bytes.

// File: rtl/pwm_busif_pkg.sv
package pwm_busif_pkg;

  typedef enum logic {
    PROTO_STROBE  = 1'b0,
    PROTO_DSTROBE = 1'b1
  } proto_e;

  // positions of the control pins inside the synchronised vector
  localparam int PIN_ADDRSTB = 0;
  localparam int PIN_DATASTB = 1;
  localparam int PIN_DIR     = 2;
  localparam int PIN_SEL_N   = 3;
  localparam int PIN_HOLD_N  = 4;
  localparam int PIN_COUNT   = 5;

endpackage

// File: rtl/wbl_sync.sv
module wbl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) pipe_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk) pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/wbl_front.sv
module wbl_front
  import pwm_busif_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          proto_sel,
  input  logic [3:0]    stb_s,
  input  logic [DW-1:0] ad_s,
  output logic          wr_evt_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);

  localparam int GUARD = SYNC + 2;
  localparam int CW    = $clog2(GUARD + 1);

  proto_e        mode_q;
  logic [CW-1:0] guard_q;
  logic [1:0]    stb_prev_q;
  logic [AW-1:0] addr_q;
  logic          armed;
  logic          addr_edge;
  logic          data_edge;

  assign armed     = (guard_q == CW'(GUARD));
  assign addr_edge = armed & stb_prev_q[PIN_ADDRSTB] & ~stb_s[PIN_ADDRSTB];

  always_comb begin
    case (mode_q)
      PROTO_STROBE:
        data_edge = armed & ~stb_prev_q[PIN_DATASTB] & stb_s[PIN_DATASTB];
      default:
        data_edge = armed & stb_prev_q[PIN_DATASTB] & ~stb_s[PIN_DATASTB]
                    & ~stb_s[PIN_DIR] & ~stb_s[PIN_SEL_N];
    endcase
  end

  always_ff @(posedge clk) begin
    stb_prev_q <= stb_s[1:0];
    if (rst) begin
      mode_q    <= proto_e'(proto_sel);
      guard_q   <= '0;
      addr_q    <= '0;
      wr_evt_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      if (!armed) guard_q <= guard_q + CW'(1);
      if (addr_edge) addr_q <= ad_s[AW-1:0];
      wr_evt_o <= data_edge;
      if (data_edge) begin
        wr_addr_o <= addr_q;
        wr_data_o <= ad_s;
      end
    end
  end

endmodule

// File: rtl/wbl_bank.sv
module wbl_bank #(
  parameter int DW     = 8,
  parameter int AW     = 3,
  parameter int NSTAGE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_evt,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 hold_n_s,
  output logic [DW*NSTAGE-1:0] ctrl_word_o,
  output logic [DW*NSTAGE-1:0] init_word_o,
  output logic                 ctrl_upd_o,
  output logic                 init_upd_o,
  output logic                 drive_en_o
);

  localparam int WORD_W   = DW * NSTAGE;
  localparam int ADR_CTRL = NSTAGE;
  localparam int ADR_INIT = NSTAGE + 1;

  logic [NSTAGE-1:0][DW-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (wr_evt) begin
      for (int g = 0; g < NSTAGE; g++) begin
        if (wr_addr == AW'(g)) stage_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_word_o <= '0;
      init_word_o <= '0;
      ctrl_upd_o  <= 1'b0;
      init_upd_o  <= 1'b0;
      drive_en_o  <= 1'b0;
    end else begin
      drive_en_o <= hold_n_s;
      ctrl_upd_o <= 1'b0;
      init_upd_o <= 1'b0;
      if (wr_evt && wr_addr == AW'(ADR_CTRL)) begin
        ctrl_word_o <= WORD_W'(stage_q);
        ctrl_upd_o  <= 1'b1;
      end
      if (wr_evt && wr_addr == AW'(ADR_INIT) && !hold_n_s) begin
        init_word_o <= WORD_W'(stage_q);
        init_upd_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wbus_param_loader.sv
module wbus_param_loader
  import pwm_busif_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int NSTAGE      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 proto_sel,
  input  logic                 hold_n,
  input  logic [DW-1:0]        ad,
  input  logic                 ale_as,
  input  logic                 wr_ds,
  input  logic                 rd_rw,
  input  logic                 cs_n,
  output logic [DW*NSTAGE-1:0] ctrl_word,
  output logic [DW*NSTAGE-1:0] init_word,
  output logic                 ctrl_upd,
  output logic                 init_upd,
  output logic                 drive_en
);

  localparam int WORD_W = DW * NSTAGE;
  localparam int SYNC_W = PIN_COUNT + DW;

  logic [SYNC_W-1:0] sync_q;
  logic              wr_evt;
  logic [AW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data;

  wbl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i ({ad, hold_n, cs_n, rd_rw, wr_ds, ale_as}),
    .q_o (sync_q)
  );

  wbl_front #(.DW(DW), .AW(AW), .SYNC(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst       (rst),
    .proto_sel (proto_sel),
    .stb_s     (sync_q[PIN_SEL_N:PIN_ADDRSTB]),
    .ad_s      (sync_q[SYNC_W-1:PIN_COUNT]),
    .wr_evt_o  (wr_evt),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  wbl_bank #(.DW(DW), .AW(AW), .NSTAGE(NSTAGE)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_evt      (wr_evt),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .hold_n_s    (sync_q[PIN_HOLD_N]),
    .ctrl_word_o (ctrl_word),
    .init_word_o (init_word),
    .ctrl_upd_o  (ctrl_upd),
    .init_upd_o  (init_upd),
    .drive_en_o  (drive_en)
  );

endmodule

// File: rtl/wbl_checker.sv
module wbl_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] ctrl_word,
  input logic [WORD_W-1:0] init_word,
  input logic              ctrl_upd,
  input logic              init_upd,
  input logic              drive_en
);

  a_r8_ctrl_single: assert property (@(posedge clk) disable iff (rst)
    ctrl_upd |=> !ctrl_upd);

  a_r8_init_single: assert property (@(posedge clk) disable iff (rst)
    init_upd |=> !init_upd);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_upd, init_upd}));

  a_r5_ctrl_steady: assert property (@(posedge clk) disable iff (rst)
    !ctrl_upd |-> $stable(ctrl_word));

  a_r6_init_steady: assert property (@(posedge clk) disable iff (rst)
    !init_upd |-> $stable(init_word));

  a_r9_init_while_held: assert property (@(posedge clk) disable iff (rst)
    init_upd |-> !drive_en);

endmodule

bind wbus_param_loader wbl_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_word (ctrl_word),
  .init_word (init_word),
  .ctrl_upd  (ctrl_upd),
  .init_upd  (init_upd),
  .drive_en  (drive_en)
);

// File: tb/wbus_param_loader_tb.sv
`timescale 1ns/1ps
module wbus_param_loader_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        proto_sel = 1'b0;
  logic        hold_n = 1'b1;
  logic [7:0]  ad = 8'h00;
  logic        ale_as = 1'b0;
  logic        wr_ds = 1'b1;
  logic        rd_rw = 1'b1;
  logic        cs_n = 1'b1;
  logic [23:0] ctrl_word, init_word;
  logic        ctrl_upd, init_upd, drive_en;

  always #2.5 clk = ~clk;

  wbus_param_loader u_dut (
    .clk(clk), .rst(rst), .proto_sel(proto_sel), .hold_n(hold_n), .ad(ad),
    .ale_as(ale_as), .wr_ds(wr_ds), .rd_rw(rd_rw), .cs_n(cs_n),
    .ctrl_word(ctrl_word), .init_word(init_word),
    .ctrl_upd(ctrl_upd), .init_upd(init_upd), .drive_en(drive_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit style = 1'b0;          // style the bench drives with
  logic [7:0] stg [3];       // bench model of staging bytes
  logic [23:0] ctrl_q [$];
  logic [23:0] init_q [$];
  string ctrl_tag_q [$];
  string init_tag_q [$];

  task automatic check(input bit ok, input string tag,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe_wr(input logic [7:0] a, input logic [7:0] d);
    ad = a; ale_as = 1'b1; cyc(4);
    ale_as = 1'b0; cyc(4);
    ad = d; cyc(4);
    wr_ds = 1'b0; cyc(4);
    wr_ds = 1'b1; cyc(4);
  endtask

  task automatic dstrobe_wr(input logic [7:0] a, input logic [7:0] d,
                            input logic rw, input logic sel_n);
    ad = a; ale_as = 1'b1; cyc(4);
    ale_as = 1'b0; cyc(4);
    ad = d; rd_rw = rw; cs_n = sel_n; cyc(4);
    wr_ds = 1'b0; cyc(4);
    wr_ds = 1'b1; ale_as = 1'b1; rd_rw = 1'b1; cs_n = 1'b1; cyc(4);
  endtask

  task automatic raw_wr(input logic [7:0] a, input logic [7:0] d);
    if (style) dstrobe_wr(a, d, 1'b0, 1'b0);
    else       strobe_wr(a, d);
  endtask

  // accepted write: update model and push expected commits
  task automatic put(input logic [7:0] a, input logic [7:0] d, input string tag);
    if (a < 3) stg[a] = d;
    else if (a == 3) begin
      ctrl_q.push_back({stg[2], stg[1], stg[0]});
      ctrl_tag_q.push_back(tag);
    end else if (a == 4 && !hold_n) begin
      init_q.push_back({stg[2], stg[1], stg[0]});
      init_tag_q.push_back(tag);
    end
    raw_wr(a, d);
    cyc(4);
  endtask

  task automatic do_reset(input bit s);
    rst = 1'b1; proto_sel = s; style = s;
    ale_as = s; wr_ds = 1'b1; rd_rw = 1'b1; cs_n = 1'b1;
    stg[0] = 8'h00; stg[1] = 8'h00; stg[2] = 8'h00;
    cyc(6);
    check(ctrl_word == 0 && init_word == 0, "R1 words cleared", ctrl_word, 24'h0);
    check(!ctrl_upd && !init_upd && !drive_en, "R1 pulses/enable low",
          {21'h0, ctrl_upd, init_upd, drive_en}, 24'h0);
    rst = 1'b0;
    cyc(8);
  endtask

  // monitor: pops expected commits as pulses appear
  logic prev_cu = 1'b0, prev_iu = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ctrl_upd) begin
        if (prev_cu) check(1'b0, "R8 ctrl pulse longer than one clock", 24'h1, 24'h0);
        if (ctrl_q.size() == 0) check(1'b0, "R8 unexpected ctrl pulse", ctrl_word, 24'h0);
        else begin
          logic [23:0] e;
          string t;
          e = ctrl_q.pop_front();
          t = ctrl_tag_q.pop_front();
          check(ctrl_word == e, t, ctrl_word, e);
        end
      end
      if (init_upd) begin
        if (prev_iu) check(1'b0, "R8 init pulse longer than one clock", 24'h1, 24'h0);
        if (init_q.size() == 0) check(1'b0, "R6 unexpected init pulse", init_word, 24'h0);
        else begin
          logic [23:0] e;
          string t;
          e = init_q.pop_front();
          t = init_tag_q.pop_front();
          check(init_word == e, t, init_word, e);
        end
      end
    end
    prev_cu <= ctrl_upd;
    prev_iu <= init_upd;
  end

  task automatic drain(input string tag);
    cyc(4);
    check(ctrl_q.size() == 0, {tag, " R8 ctrl pulses all seen"}, 24'(ctrl_q.size()), 24'h0);
    check(init_q.size() == 0, {tag, " R8 init pulses all seen"}, 24'(init_q.size()), 24'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // ---------------- strobe style ----------------
    do_reset(1'b0);
    hold_n = 1'b0; cyc(6);
    check(drive_en == 1'b0, "R9 enable low under hold", {23'h0, drive_en}, 24'h0);
    put(8'h00, 8'h11, "R2 staging S0");
    put(8'h01, 8'h22, "R2 staging S1");
    put(8'h02, 8'h33, "R2 staging S2");
    check(ctrl_word == 0 && init_word == 0, "R4 staging has no effect", ctrl_word, 24'h0);
    put(8'h04, 8'hFF, "R6 init commit under hold");
    put(8'h03, 8'h5C, "R5 ctrl commit data ignored");
    check(ctrl_word == 24'h332211, "R5 ctrl byte order", ctrl_word, 24'h332211);
    hold_n = 1'b1; cyc(6);
    check(drive_en == 1'b1, "R9 enable follows hold release", {23'h0, drive_en}, 24'h1);
    put(8'h01, 8'h99, "R6 staging S1");
    raw_wr(8'h04, 8'h00); cyc(4);
    check(init_word == 24'h332211, "R6 init ignored when not held", init_word, 24'h332211);
    // unused addresses and read strobe / chip select pulses
    raw_wr(8'h05, 8'hA5);
    raw_wr(8'h06, 8'hA6);
    raw_wr(8'h07, 8'hA7);
    rd_rw = 1'b0; cs_n = 1'b0; cyc(4); rd_rw = 1'b1; cs_n = 1'b1; cyc(4);
    put(8'h03, 8'h00, "R7 unused addresses leave staging");
    put(8'h01, 8'hAB, "R11 staging S1");
    put(8'h03, 8'h00, "R11 untouched bytes persist");
    // strap flipped after reset: strobe style must stay in force
    proto_sel = 1'b1; cyc(4);
    put(8'h00, 8'h5A, "R10 staging after strap change");
    put(8'h03, 8'h00, "R10 strobe style kept after strap change");
    check(ctrl_word == 24'h33AB5A, "R10 ctrl after strap change", ctrl_word, 24'h33AB5A);
    drain("strobe");

    // ---------------- data-strobe style ----------------
    do_reset(1'b1);
    put(8'h00, 8'hC1, "R3 staging S0");
    put(8'h01, 8'hC2, "R3 staging S1");
    put(8'h02, 8'hC3, "R3 staging S2");
    put(8'h03, 8'h00, "R3 ctrl commit data-strobe");
    dstrobe_wr(8'h00, 8'hEE, 1'b0, 1'b1);   // chip select high: ignored
    dstrobe_wr(8'h01, 8'hEE, 1'b1, 1'b0);   // read direction: ignored
    dstrobe_wr(8'h03, 8'h00, 1'b1, 1'b0);   // commit as read: ignored
    cyc(4);
    put(8'h03, 8'h00, "R3 gated strobes ignored");
    check(ctrl_word == 24'hC3C2C1, "R3 ctrl value", ctrl_word, 24'hC3C2C1);
    proto_sel = 1'b0; cyc(4);
    put(8'h02, 8'h7E, "R10 staging data-strobe after strap change");
    hold_n = 1'b0; cyc(6);
    put(8'h04, 8'h00, "R10 init commit data-strobe after strap change");
    check(init_word == 24'h7EC2C1, "R6 init value data-strobe", init_word, 24'h7EC2C1);
    drain("data-strobe");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule